// File: doc/BRIEF.md
# Direction-Gated Distance Pulse Counter

This block counts pulses arriving on two independent distance inputs, one counter per input. Each pulse input and a shared drive-state line are first brought into the clock domain and cleaned of short glitches; a clean rising edge on a pulse input then moves that channel's counter by one step.

The step direction comes from a rule that the host controls. A control bit, written through a small register port, decides whether the drive-state line is used at all. While the bit is clear, which it is after reset, every channel counts up. While it is set, the drive-state line picks the direction: high counts up and low counts down.

A single-cycle sample strobe copies both live counts into latch registers at once. The host reads these latches through the same register port. Reading never changes the live counters.

Top module: `dist_pulse_counter`

## Requirements
- R1: After reset, both live counters, both latch registers and the control bit are zero. Reads at address 0 (control), 1 (channel 0 latch) and 2 (channel 1 latch) return 0.
- R2: Each clean rising edge on a channel's pulse input changes that channel's counter by exactly one step. A level held high does not count again.
- R3: A pulse input or drive-state level is accepted only once it has been seen for 3 consecutive synchronized samples. A pulse lasting 1 or 2 clock cycles is ignored, and a pulse lasting 3 cycles is counted.
- R4: The control bit is bit 0 of address 0 and reads back as written. While it is 0, counters count up whatever the drive-state line holds.
- R5: While the control bit is 1, a drive-state level of 1 makes the counters count up and a level of 0 makes them count down.
- R6: Counters wrap modulo 2^CNT_W in both directions: up from all ones gives zero, and down from zero gives all ones.
- R7: A sample strobe copies both live counts into their latches in the same cycle. A latch keeps its value until the next strobe, even while its counter moves on.
- R8: Reads are side-effect free. Repeated reads leave the live counts unchanged, and a write to an address other than 0 changes nothing.
- R9: The two channels are independent. Pulses on one channel never change the other channel's count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pulse_in | input | NCH | Raw distance pulse inputs, one bit per channel |
| drive_dir_in | input | 1 | Raw drive-state line (1 = forward) |
| sample_stb | input | 1 | Single-cycle strobe that copies counts into latches |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | CNT_W | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | CNT_W | Read data for rd_addr (combinational) |

## Verification
The bench builds the block with CNT_W = 4 and keeps the default two channels and 3-sample filter. With a 16-value counter, every combination of control bit and drive-state level can be swept over pulse counts that cross the wrap point in both directions, with the expected latch values computed as modular sums. The two channels receive complementary pulse counts in each batch, which exercises their independence. Separate passes cover glitches of 1, 2 and 3 cycles, a latch that holds while its counter moves on, and writes to addresses other than the control register.

// File: rtl/dpc_pkg.sv
// Package: shared register-map helpers for the distance pulse counter.
// Assumes channel latches occupy consecutive addresses after the control word.
package dpc_pkg;
    localparam int unsigned CTRL_ADDR  = 0;  // control word, bit 0 = use drive-state line
    localparam int unsigned LATCH_BASE = 1;  // first channel latch address

    // Address of the latch register belonging to channel ch.
    function automatic int unsigned latch_addr(input int unsigned ch);
        return LATCH_BASE + ch;
    endfunction
endpackage

// File: rtl/dpc_input_cond.sv
// Module: dpc_input_cond
// Brings one asynchronous level into the clock domain through SYNC_N flops,
// then accepts a new level only after FILT_N identical synchronized samples.
// Emits the filtered level and a one-cycle pulse on each accepted rising edge.
// Assumes SYNC_N >= 2 and FILT_N >= 2.
module dpc_input_cond #(
    parameter int unsigned SYNC_N = 2,
    parameter int unsigned FILT_N = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level_q,
    output logic rise_q
);
    logic [SYNC_N-1:0] sync_q;
    logic [FILT_N-1:0] hist_q;
    logic              all_hi;
    logic              all_lo;

    // Synchronizer chain for the raw input.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_N-2:0], din};
    end

    // History of the most recent synchronized samples.
    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= {hist_q[FILT_N-2:0], sync_q[SYNC_N-1]};
    end

    // Agreement detection across the sample history.
    always_comb begin
        all_hi = &hist_q;
        all_lo = ~|hist_q;
    end

    // Filtered level and its registered rising-edge pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= 1'b0;
            rise_q  <= 1'b0;
        end else begin
            if (all_hi)      level_q <= 1'b1;
            else if (all_lo) level_q <= 1'b0;
            rise_q <= all_hi & ~level_q;
        end
    end

    // R3: the filtered level only moves after the history agreed.
    a_r3_level_needs_agreement: assert property (@(posedge clk) disable iff (!rst_n)
        (level_q != $past(level_q)) |-> ($past(all_hi) || $past(all_lo)));

    // R2: an edge pulse is never followed by another while the level stays.
    a_r2_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
        rise_q |=> !rise_q);

    // R2: an edge pulse coincides with a freshly raised level.
    a_r2_rise_on_new_level: assert property (@(posedge clk) disable iff (!rst_n)
        rise_q |-> (level_q && !$past(level_q)));
endmodule

// File: rtl/dpc_updown_counter.sv
// Module: dpc_updown_counter
// One channel: a wrapping up/down counter that steps on a one-cycle request,
// plus a snapshot latch loaded on the sample strobe. The latch takes the
// count as it stands before any step in the same cycle.
module dpc_updown_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             count_up,
    input  logic             snap,
    output logic [CNT_W-1:0] latch_q
);
    logic [CNT_W-1:0] cnt_q;

    // Live count: one step per request, modulo 2^CNT_W.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (step)  cnt_q <= count_up ? cnt_q + 1'b1 : cnt_q - 1'b1;
    end

    // Snapshot register loaded by the shared strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     latch_q <= '0;
        else if (snap)  latch_q <= cnt_q;
    end

    // R1: counter and latch leave reset at zero.
    a_r1_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cnt_q == '0 && latch_q == '0));

    // R5: an up step adds exactly one.
    a_r5_step_up: assert property (@(posedge clk) disable iff (!rst_n)
        (step && count_up) |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R5: a down step removes exactly one.
    a_r5_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !count_up) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R8: without a step request the count holds.
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(cnt_q));

    // R7: the strobe captures the pre-step count; otherwise the latch holds.
    a_r7_snap: assert property (@(posedge clk) disable iff (!rst_n)
        snap |=> (latch_q == $past(cnt_q)));
    a_r7_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !snap |=> $stable(latch_q));
endmodule

// File: rtl/dist_pulse_counter.sv
// Module: dist_pulse_counter (top)
// Conditions NCH pulse inputs and one drive-state line, counts clean rising
// edges per channel with a direction gated by a host control bit, snapshots
// all counts on sample_stb, and exposes control and snapshots on a simple
// register port. Assumes sample_stb and the register port are synchronous.
module dist_pulse_counter #(
    parameter int unsigned NCH    = 2,
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned SYNC_N = 2,
    parameter int unsigned FILT_N = 3,
    localparam int unsigned ADDR_W = $clog2(NCH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    pulse_in,
    input  logic              drive_dir_in,
    input  logic              sample_stb,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data
);
    import dpc_pkg::*;

    logic [NCH-1:0]   step;
    logic [NCH-1:0]   lvl_unused;
    logic [CNT_W-1:0] lat [NCH];
    logic             dir_lvl;
    logic             dir_rise_unused;
    logic             dir_en_q;
    logic             count_up;

    // Conditioning for the drive-state line.
    dpc_input_cond #(.SYNC_N(SYNC_N), .FILT_N(FILT_N)) u_dir_cond (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (drive_dir_in),
        .level_q(dir_lvl),
        .rise_q (dir_rise_unused)
    );

    // Host control bit: enables the drive-state direction rule.
    always_ff @(posedge clk) begin
        if (!rst_n) dir_en_q <= 1'b0;
        else if (wr_en && wr_addr == ADDR_W'(CTRL_ADDR)) dir_en_q <= wr_data[0];
    end

    // Direction rule shared by all channels.
    always_comb count_up = !dir_en_q || dir_lvl;

    // Per-channel conditioning and counting.
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        dpc_input_cond #(.SYNC_N(SYNC_N), .FILT_N(FILT_N)) u_cond (
            .clk    (clk),
            .rst_n  (rst_n),
            .din    (pulse_in[g]),
            .level_q(lvl_unused[g]),
            .rise_q (step[g])
        );

        dpc_updown_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .step    (step[g]),
            .count_up(count_up),
            .snap    (sample_stb),
            .latch_q (lat[g])
        );
    end

    // Read multiplexer over control word and latches.
    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(CTRL_ADDR)) rd_data[0] = dir_en_q;
        for (int i = 0; i < NCH; i++) begin
            if (rd_addr == ADDR_W'(latch_addr(i))) rd_data = lat[i];
        end
    end

    // R4: the control bit moves only on a write to the control address.
    a_r4_ctrl_write_only: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == ADDR_W'(CTRL_ADDR)) |=> $stable(dir_en_q));

    // R4: with the direction rule disabled every step counts up.
    a_r4_up_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_en_q && |step) |-> count_up);
endmodule

// File: tb/dist_pulse_counter_tb.sv
`timescale 1ns/1ps
// Bench: sweeps control bit, drive-state level and pulse counts on a 4-bit
// build, comparing latch reads with modular sums computed here.
module dist_pulse_counter_tb;
    localparam int unsigned NCH = 2;
    localparam int unsigned CW  = 4;
    localparam int unsigned AW  = 2;
    localparam int unsigned MOD = 1 << CW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NCH-1:0] pulse_in = '0;
    logic          drive_dir_in = 1'b0;
    logic          sample_stb = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [CW-1:0] wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [CW-1:0] rd_data;

    int checks = 0;
    int errors = 0;
    int m0 = 0;
    int m1 = 0;

    always #2.5 clk = ~clk;

    dist_pulse_counter #(.NCH(NCH), .CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .drive_dir_in(drive_dir_in),
        .sample_stb(sample_stb), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic rd(input int addr, output int val);
        @(negedge clk);
        rd_addr = AW'(addr);
        #1 val = int'(rd_data);
    endtask

    task automatic wr(input int addr, input int val);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(addr); wr_data = CW'(val);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic strobe();
        @(negedge clk);
        sample_stb = 1'b1;
        @(negedge clk);
        sample_stb = 1'b0;
        cyc(1);
    endtask

    // n0 / n1 clean pulses on channels 0 / 1, then settle.
    task automatic pulses(input int n0, input int n1, input int width);
        int n;
        n = (n0 > n1) ? n0 : n1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            pulse_in = {(i < n1), (i < n0)};
            cyc(width);
            pulse_in = '0;
            cyc(6);
        end
        cyc(12);
    endtask

    task automatic check_latches(input string tag);
        int v;
        rd(1, v); check({tag, " ch0"}, v, m0);
        rd(2, v); check({tag, " ch1"}, v, m1);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(5ns * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int v;
        cyc(4);
        rst_n = 1'b1;
        cyc(2);
        // R1: reset state of control word and latches.
        rd(0, v); check("R1 ctrl", v, 0);
        rd(1, v); check("R1 lat0", v, 0);
        rd(2, v); check("R1 lat1", v, 0);

        // R4 R5 R6 R9 R2: sweep control bit, direction and pulse counts.
        for (int mode = 0; mode < 4; mode++) begin
            int en;
            int dr;
            int up;
            en = mode >> 1; dr = mode & 1;
            wr(0, en);
            rd(0, v); check("R4 ctrl readback", v, en);
            @(negedge clk); drive_dir_in = dr[0];
            cyc(10);
            up = (en == 0 || dr == 1) ? 1 : 0;
            for (int n = 0; n < 18; n++) begin
                pulses(n, 17 - n, 4);
                m0 = (m0 + (up ? n : MOD - n)) % MOD;
                m1 = (m1 + (up ? 17 - n : MOD - (17 - n))) % MOD;
                strobe();
                check_latches(up ? "R5 R6 R9 up sweep" : "R5 R6 R9 down sweep");
            end
        end

        // R3: glitches of 1 and 2 cycles are ignored; 3 cycles counts.
        wr(0, 0);
        cyc(4);
        pulses(1, 1, 1);
        pulses(1, 1, 2);
        strobe();
        check_latches("R3 glitch ignored");
        pulses(1, 0, 3);
        m0 = (m0 + 1) % MOD;
        strobe();
        check_latches("R3 three-cycle pulse");

        // R7: latch holds while counter moves; R8: reads do not disturb.
        pulses(3, 5, 4);
        check_latches("R7 latch holds");
        for (int k = 0; k < 5; k++) begin
            rd(1, v); rd(2, v);
        end
        // R8: writes to latch addresses are ignored.
        wr(1, 9); wr(2, 9); wr(3, 9);
        m0 = (m0 + 3) % MOD;
        m1 = (m1 + 5) % MOD;
        strobe();
        check_latches("R8 no disturbance");
        rd(0, v); check("R8 ctrl untouched", v, 0);

        // R2: level held high counts once.
        @(negedge clk); pulse_in = 2'b01;
        cyc(40);
        pulse_in = '0;
        cyc(12);
        m0 = (m0 + 1) % MOD;
        strobe();
        check_latches("R2 long level");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule